// File: doc/BRIEF.md
# Dual-Host Ownership Semaphore Arbiter

This block decides which of two bus hosts, a primary and a secondary, may write a small bank of shared configuration registers. A single 2-bit ownership code is held in one register. Each host sees it through its own request port, which has a write strobe, 2-bit write data and 2-bit read-back. Three of the four code values leave the primary in charge. One of those three also bars the secondary from asking for ownership. The remaining value hands ownership to the secondary, and after that only the secondary can change the code again.

The bank holds four 32-bit protected registers. Each host has its own write strobe, address and data, plus a combinational read path. Either host may read at any time. A write lands only when the writing host owns the bank at that edge. A write from the other host is silently dropped. The ownership code and one write-permission flag per host are also brought out as outputs.

The state machine has four named states. FREE (00) and OPEN (11) are primary-owned and accept a request from the secondary. LOCK (10) is primary-owned and refuses requests from the secondary. SEC (01) is secondary-owned. The transitions are:
- PRI_SET: from FREE, OPEN or LOCK, a primary write moves to the written code. This includes a handover to SEC.
- SEC_GRAB: from FREE or OPEN, a secondary write of 01, with no primary write in the same cycle, moves to SEC.
- SEC_RELEASE: from SEC, a secondary write moves to the written code.
- HOLD: every other case leaves the state unchanged.

Top module: `own_sem_arbiter`

## Requirements
- R1: After reset, the ownership code is 00 (FREE), both request read-backs are 00, the primary permission flag is 1, the secondary permission flag is 0, and all four protected registers read 0.
- R2: The code 01 sets `sec_may_write`=1 and `pri_may_write`=0. The codes 00, 10 and 11 set `pri_may_write`=1 and `sec_may_write`=0.
- R3: `pri_req_rdata` and `sec_req_rdata` always both equal `own_state`.
- R4: When the code is not 01 and both hosts write their request ports in the same cycle, the next code is the primary's write data.
- R5: When the code is 00, 10 or 11, a primary request write of any value becomes the code at the next clock edge.
- R6: When the code is 00 or 11 and the primary does not write, a secondary request write of 01 sets the code to 01 at the next edge. A secondary write of any other value leaves the code unchanged.
- R7: When the code is 10, secondary request writes of any value leave the code unchanged.
- R8: When the code is 01, primary request writes are ignored. This holds even when the primary writes in the same cycle as the secondary. A secondary write of any value becomes the next code.
- R9: Protected register n is selected by address value n, for n from 0 to 3. A write by the current owner updates it at the next edge. A write by the non-owner is dropped and leaves all registers unchanged.
- R10: Both hosts read the current contents of the addressed protected register combinationally, whichever host is the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_req_we | input | 1 | Primary request write strobe |
| pri_req_wdata | input | 2 | Primary requested code |
| pri_req_rdata | output | 2 | Ownership code as seen by the primary |
| sec_req_we | input | 1 | Secondary request write strobe |
| sec_req_wdata | input | 2 | Secondary requested code |
| sec_req_rdata | output | 2 | Ownership code as seen by the secondary |
| pri_cfg_we | input | 1 | Primary protected-register write strobe |
| pri_cfg_addr | input | 2 | Primary register select (read and write) |
| pri_cfg_wdata | input | 32 | Primary write data |
| pri_cfg_rdata | output | 32 | Primary read data |
| sec_cfg_we | input | 1 | Secondary protected-register write strobe |
| sec_cfg_addr | input | 2 | Secondary register select (read and write) |
| sec_cfg_wdata | input | 32 | Secondary write data |
| sec_cfg_rdata | output | 32 | Secondary read data |
| own_state | output | 2 | Current ownership code |
| pri_may_write | output | 1 | Primary currently owns the bank |
| sec_may_write | output | 1 | Secondary currently owns the bank |

## Verification
The bench starts from each of the four codes and sweeps every combination of the two request strobes and data values. This catches three kinds of fault. A design that lets the secondary grab from LOCK fails the sweep. So does one that lets the primary pull ownership back from SEC. A design that lets the secondary win a same-cycle tie while the primary owns fails it as well. A second sweep has both hosts write protected registers at every address pair under every code, then reads the whole bank back through both ports. A write gate keyed to the wrong host, or a dropped write that still corrupts a neighbouring register, shows up as a wrong read.

// File: rtl/own_sem_pkg.sv
package own_sem_pkg;
    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        OWN_FREE = 2'b00,
        OWN_SEC  = 2'b01,
        OWN_LOCK = 2'b10,
        OWN_OPEN = 2'b11
    } own_code_e;
endpackage

// File: rtl/own_sem_fsm.sv
module own_sem_fsm
    import own_sem_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pri_we,
    input  logic [CODE_W-1:0] pri_code,
    input  logic              sec_we,
    input  logic [CODE_W-1:0] sec_code,
    output own_code_e         state_q,
    output logic              pri_owner,
    output logic              sec_owner
);
    own_code_e state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_SEC: begin
                if (sec_we) state_d = own_code_e'(sec_code);        // SEC_RELEASE
            end
            OWN_LOCK: begin
                if (pri_we) state_d = own_code_e'(pri_code);        // PRI_SET
            end
            OWN_FREE, OWN_OPEN: begin
                if (pri_we)
                    state_d = own_code_e'(pri_code);                // PRI_SET
                else if (sec_we && (sec_code == OWN_SEC))
                    state_d = OWN_SEC;                              // SEC_GRAB
            end
            default: state_d = OWN_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OWN_FREE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        sec_owner = (state_q == OWN_SEC);
        pri_owner = !sec_owner;
    end

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OWN_LOCK && !pri_we) |=> (state_q == OWN_LOCK));          // R7
    AST_SEC_ONLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OWN_SEC && !sec_we) |=> (state_q == OWN_SEC));            // R8
    AST_PRI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != OWN_SEC && pri_we) |=> (state_q == $past(pri_code)));     // R4
    AST_SEC_GRAB: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == OWN_FREE || state_q == OWN_OPEN) && !pri_we && sec_we
         && sec_code == 2'b01) |=> (state_q == OWN_SEC));                     // R6
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pri_owner, sec_owner}) == 1);                             // R2
endmodule

// File: rtl/own_cfg_bank.sv
module own_cfg_bank #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pri_owner,
    input  logic              sec_owner,
    input  logic              pri_we,
    input  logic [ADDR_W-1:0] pri_addr,
    input  logic [DATA_W-1:0] pri_wdata,
    input  logic              sec_we,
    input  logic [ADDR_W-1:0] sec_addr,
    input  logic [DATA_W-1:0] sec_wdata,
    output logic [DATA_W-1:0] pri_rdata,
    output logic [DATA_W-1:0] sec_rdata
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic pri_hit, sec_hit;
        assign pri_hit = pri_owner && pri_we && (pri_addr == ADDR_W'(i));
        assign sec_hit = sec_owner && sec_we && (sec_addr == ADDR_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       regs_q[i] <= '0;
            else if (pri_hit) regs_q[i] <= pri_wdata;
            else if (sec_hit) regs_q[i] <= sec_wdata;
        end

        AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (!(pri_owner && pri_we && pri_addr == ADDR_W'(i))
             && !(sec_owner && sec_we && sec_addr == ADDR_W'(i)))
            |=> $stable(regs_q[i]));                                          // R9
    end

    assign pri_rdata = regs_q[pri_addr];
    assign sec_rdata = regs_q[sec_addr];
endmodule

// File: rtl/own_sem_arbiter.sv
module own_sem_arbiter
    import own_sem_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pri_req_we,
    input  logic [CODE_W-1:0] pri_req_wdata,
    output logic [CODE_W-1:0] pri_req_rdata,
    input  logic              sec_req_we,
    input  logic [CODE_W-1:0] sec_req_wdata,
    output logic [CODE_W-1:0] sec_req_rdata,
    input  logic              pri_cfg_we,
    input  logic [ADDR_W-1:0] pri_cfg_addr,
    input  logic [DATA_W-1:0] pri_cfg_wdata,
    output logic [DATA_W-1:0] pri_cfg_rdata,
    input  logic              sec_cfg_we,
    input  logic [ADDR_W-1:0] sec_cfg_addr,
    input  logic [DATA_W-1:0] sec_cfg_wdata,
    output logic [DATA_W-1:0] sec_cfg_rdata,
    output logic [CODE_W-1:0] own_state,
    output logic              pri_may_write,
    output logic              sec_may_write
);
    own_code_e state_q;
    logic      pri_owner, sec_owner;

    own_sem_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pri_we    (pri_req_we),
        .pri_code  (pri_req_wdata),
        .sec_we    (sec_req_we),
        .sec_code  (sec_req_wdata),
        .state_q   (state_q),
        .pri_owner (pri_owner),
        .sec_owner (sec_owner)
    );

    own_cfg_bank #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .pri_owner (pri_owner),
        .sec_owner (sec_owner),
        .pri_we    (pri_cfg_we),
        .pri_addr  (pri_cfg_addr),
        .pri_wdata (pri_cfg_wdata),
        .sec_we    (sec_cfg_we),
        .sec_addr  (sec_cfg_addr),
        .sec_wdata (sec_cfg_wdata),
        .pri_rdata (pri_cfg_rdata),
        .sec_rdata (sec_cfg_rdata)
    );

    assign own_state     = state_q;
    assign pri_req_rdata = state_q;
    assign sec_req_rdata = state_q;
    assign pri_may_write = pri_owner;
    assign sec_may_write = sec_owner;

    AST_READBACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (pri_req_rdata == sec_req_rdata) && (pri_req_rdata == own_state));    // R3
    AST_SEC_FLAG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        sec_may_write == (own_state == 2'b01));                               // R2
endmodule

// File: tb/tb_own_sem_arbiter.sv
module tb_own_sem_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_REGS   = 4;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pri_req_we = 1'b0, sec_req_we = 1'b0;
    logic [1:0] pri_req_wdata = '0, sec_req_wdata = '0;
    logic [1:0] pri_req_rdata, sec_req_rdata, own_state;
    logic pri_cfg_we = 1'b0, sec_cfg_we = 1'b0;
    logic [ADDR_W-1:0] pri_cfg_addr = '0, sec_cfg_addr = '0;
    logic [DATA_W-1:0] pri_cfg_wdata = '0, sec_cfg_wdata = '0;
    logic [DATA_W-1:0] pri_cfg_rdata, sec_cfg_rdata;
    logic pri_may_write, sec_may_write;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [DATA_W-1:0] exp_reg [NUM_REGS];

    always #(CLK_PERIOD/2) clk = ~clk;

    own_sem_arbiter #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .pri_req_we(pri_req_we), .pri_req_wdata(pri_req_wdata), .pri_req_rdata(pri_req_rdata),
        .sec_req_we(sec_req_we), .sec_req_wdata(sec_req_wdata), .sec_req_rdata(sec_req_rdata),
        .pri_cfg_we(pri_cfg_we), .pri_cfg_addr(pri_cfg_addr), .pri_cfg_wdata(pri_cfg_wdata),
        .pri_cfg_rdata(pri_cfg_rdata),
        .sec_cfg_we(sec_cfg_we), .sec_cfg_addr(sec_cfg_addr), .sec_cfg_wdata(sec_cfg_wdata),
        .sec_cfg_rdata(sec_cfg_rdata),
        .own_state(own_state), .pri_may_write(pri_may_write), .sec_may_write(sec_may_write)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [1:0] model_next(input logic [1:0] s, input bit pwe,
            input logic [1:0] pd, input bit swe, input logic [1:0] sd);
        if (s == 2'b01) return swe ? sd : s;
        if (pwe) return pd;
        if (swe && sd == 2'b01 && s != 2'b10) return 2'b01;
        return s;
    endfunction

    task automatic idle();
        pri_req_we = 1'b0; sec_req_we = 1'b0;
        pri_cfg_we = 1'b0; sec_cfg_we = 1'b0;
    endtask

    // inputs are set shortly after a rising edge, take effect at the next one
    task automatic cycle();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic force_state(input logic [1:0] s);
        if (own_state == 2'b01) begin
            sec_req_we = 1'b1; sec_req_wdata = 2'b00;
            cycle();
        end
        pri_req_we = 1'b1; pri_req_wdata = s;
        cycle();
        chk("R5 primary set", {30'd0, own_state}, {30'd0, s});
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NUM_REGS; r++) exp_reg[r] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 state", {30'd0, own_state}, 32'd0);
        chk("R1 pri readback", {30'd0, pri_req_rdata}, 32'd0);
        chk("R1 sec readback", {30'd0, sec_req_rdata}, 32'd0);
        chk("R1 pri flag", {31'd0, pri_may_write}, 32'd1);
        chk("R1 sec flag", {31'd0, sec_may_write}, 32'd0);
        for (int r = 0; r < NUM_REGS; r++) begin
            pri_cfg_addr = ADDR_W'(r); sec_cfg_addr = ADDR_W'(r);
            #1;
            chk("R1 reg pri", pri_cfg_rdata, 32'd0);
            chk("R1 reg sec", sec_cfg_rdata, 32'd0);
        end

        // exhaustive request sweep
        for (int s = 0; s < 4; s++)
            for (int pw = 0; pw < 2; pw++)
                for (int pd = 0; pd < 4; pd++)
                    for (int sw = 0; sw < 2; sw++)
                        for (int sd = 0; sd < 4; sd++) begin
                            logic [1:0] exp;
                            string tag;
                            force_state(2'(s));
                            pri_req_we = pw[0]; pri_req_wdata = 2'(pd);
                            sec_req_we = sw[0]; sec_req_wdata = 2'(sd);
                            exp = model_next(2'(s), pw[0], 2'(pd), sw[0], 2'(sd));
                            cycle();
                            if (s == 1)              tag = "R8 secondary-held";
                            else if (pw == 1 && sw == 1) tag = "R4 tie";
                            else if (pw == 1)        tag = "R5 primary write";
                            else if (s == 2)         tag = "R7 locked";
                            else                     tag = "R6 secondary request";
                            chk(tag, {30'd0, own_state}, {30'd0, exp});
                            chk("R3 pri readback", {30'd0, pri_req_rdata}, {30'd0, exp});
                            chk("R3 sec readback", {30'd0, sec_req_rdata}, {30'd0, exp});
                            chk("R2 pri flag", {31'd0, pri_may_write}, {31'd0, exp != 2'b01});
                            chk("R2 sec flag", {31'd0, sec_may_write}, {31'd0, exp == 2'b01});
                        end

        // protected register sweep
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < NUM_REGS; a++)
                for (int b = 0; b < NUM_REGS; b++) begin
                    logic [31:0] pv, sv;
                    pv = 32'hA000_0000 | 32'(s << 8) | 32'(a << 4) | 32'(b);
                    sv = 32'h5000_0000 | 32'(s << 8) | 32'(a << 4) | 32'(b);
                    force_state(2'(s));
                    pri_cfg_we = 1'b1; pri_cfg_addr = ADDR_W'(a); pri_cfg_wdata = pv;
                    sec_cfg_we = 1'b1; sec_cfg_addr = ADDR_W'(b); sec_cfg_wdata = sv;
                    if (s == 1) exp_reg[b] = sv;
                    else        exp_reg[a] = pv;
                    cycle();
                    for (int r = 0; r < NUM_REGS; r++) begin
                        pri_cfg_addr = ADDR_W'(r); sec_cfg_addr = ADDR_W'(r);
                        #1;
                        chk("R9 owner write / R10 pri read", pri_cfg_rdata, exp_reg[r]);
                        chk("R10 sec read", sec_cfg_rdata, exp_reg[r]);
                    end
                end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule